// File: doc/BRIEF.md
# Dual-Channel FIFO Status Controller

This block produces the status and interrupt logic for a two-channel serial codec port. The two channels are audio and telecom, and each has a transmit FIFO and a receive FIFO. The FIFO storage is not part of the block. Each FIFO is represented only by an occupancy counter that follows the push and pop strobes of its producer and consumer. From the four occupancy counts and a port-enable bit, the block derives:

- level-based service requests,
- sticky error flags for pops from an empty transmit FIFO and pushes into a full receive FIFO,
- not-full and not-empty indicators for the receive FIFOs.

Four plain codec status inputs are passed through into the same word.

Software reads the 32-bit status word directly from the `status_word` output. It clears sticky error flags with a single-cycle write strobe and a write-one-to-clear data word. The flags can be cleared while the port is still disabled, so the port can start from a clean state. A single registered interrupt line combines the service requests that are enabled by a per-FIFO mask with any error flag that is set. All pins are plain control and status pins. No data stream crosses the block edge, so no valid/ready handshake is used.

FIFO index order on every 4-bit vector is: 0 audio transmit, 1 audio receive, 2 telecom transmit, 3 telecom receive.

Top module: `codec_fifo_status`

## Requirements
- R1: Each FIFO count runs from 0 to 8. At a clock edge, a push raises the count by one unless the count is 8, and a pop lowers it by one unless the count is 0. Both checks use the count before the edge. A blocked push or pop leaves the count unchanged.
- R2: The transmit service bits, bit 0 (audio) and bit 2 (telecom), read 1 exactly when `port_en` is 1 and that transmit count is 4 or less.
- R3: The receive service bits, bit 1 (audio) and bit 3 (telecom), read 1 exactly when `port_en` is 1 and that receive count is 6 or more.
- R4: Bit 4 (audio) and bit 6 (telecom) become 1 in the cycle after a pop on their transmit FIFO while its count is 0. Bit 5 (audio) and bit 7 (telecom) become 1 in the cycle after a push on their receive FIFO while its count is 8. Both happen whatever the value of `port_en`.
- R5: Bits 4 to 7 hold their value until a write (`sw_wr`=1) carries a 1 in that bit position, which clears the bit at the next edge. A 0 in that position leaves the bit unchanged. A set event in the same cycle wins over the clear. Write data in bits 0 to 3 and 8 to 31 has no effect.
- R6: Bits 8 to 11 are, in order: audio receive not-full (count<8), audio receive not-empty (count>0), telecom receive not-full, and telecom receive not-empty.
- R7: Bits 12 to 15 mirror, in order: `wr_done`, `rd_done`, `aud_codec_on` and `tel_codec_on`.
- R8: Bits 16 to 31 always read 0.
- R9: `irq` is registered. After each edge it equals the OR of (service bit i AND `svc_mask[i]`) for every i, together with bits 4 to 7, all taken from before that edge.
- R10: While `rst_n` is 0, all counts and error flags are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; gates the service bits |
| push | input | 4 | Per-FIFO push strobe |
| pop | input | 4 | Per-FIFO pop strobe |
| svc_mask | input | 4 | Per-FIFO service-request interrupt enable |
| wr_done | input | 1 | Codec write-complete indication, mirrored to bit 12 |
| rd_done | input | 1 | Codec read-complete indication, mirrored to bit 13 |
| aud_codec_on | input | 1 | Audio codec enabled, mirrored to bit 14 |
| tel_codec_on | input | 1 | Telecom codec enabled, mirrored to bit 15 |
| sw_wr | input | 1 | Status write strobe |
| sw_wdata | input | 32 | Write data; 1s in bits 4 to 7 clear error flags |
| status_word | output | 32 | Status read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong occupancy count is hidden until it crosses a threshold. It then shows as a service bit, or a receive not-full or not-empty bit, that disagrees with the count kept by the bench. An underflow or overflow of a count shows as a missing or spurious error bit at the next pop on empty or push on full. The bench therefore drives the counts hard against both ends, so that such faults appear within a few cycles. A fault in the error flags or in the mask shows in `status_word` one cycle after the causing edge, and in `irq` one cycle after that.

// File: rtl/codec_stat_pkg.sv
package codec_stat_pkg;
  localparam int NUM_FIFO = 4;
  localparam int FIFO_DEPTH = 8;
  localparam int TX_SVC_MAX = 4;
  localparam int RX_SVC_MIN = 6;
  localparam int STAT_W = 32;

  typedef enum logic [1:0] {
    FIFO_AUD_TX = 2'd0,
    FIFO_AUD_RX = 2'd1,
    FIFO_TEL_TX = 2'd2,
    FIFO_TEL_RX = 2'd3
  } fifo_id_e;

  // Even indices are transmit FIFOs, odd are receive FIFOs
  function automatic bit fifo_is_tx(int idx);
    return (idx % 2) == 0;
  endfunction
endpackage

// File: rtl/fifo_level_tracker.sv
module fifo_level_tracker #(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] level,
  output logic             not_full,
  output logic             not_empty,
  output logic             push_blocked,
  output logic             pop_blocked
);
  logic push_ok;
  logic pop_ok;

  assign not_full     = (level != LVL_W'(DEPTH));
  assign not_empty    = (level != '0);
  assign push_ok      = push & not_full;
  assign pop_ok       = pop & not_empty;
  assign push_blocked = push & ~not_full;
  assign pop_blocked  = pop & ~not_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
    end else begin
      case ({push_ok, pop_ok})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/service_request.sv
module service_request #(
  parameter bit IS_TX = 1'b1,
  parameter int DEPTH = 8,
  parameter int THRESH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             enable,
  input  logic [LVL_W-1:0] level,
  output logic             req
);
  generate
    if (IS_TX) begin : g_tx
      assign req = enable & (level <= LVL_W'(THRESH));
    end else begin : g_rx
      assign req = enable & (level >= LVL_W'(THRESH));
    end
  endgenerate
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end
endmodule

// File: rtl/codec_fifo_status.sv
module codec_fifo_status
  import codec_stat_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH,
  parameter int TX_MAX = TX_SVC_MAX,
  parameter int RX_MIN = RX_SVC_MIN,
  localparam int NF = NUM_FIFO,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int ERR_LSB = NF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic [NF-1:0]     push,
  input  logic [NF-1:0]     pop,
  input  logic [NF-1:0]     svc_mask,
  input  logic              wr_done,
  input  logic              rd_done,
  input  logic              aud_codec_on,
  input  logic              tel_codec_on,
  input  logic              sw_wr,
  input  logic [STAT_W-1:0] sw_wdata,
  output logic [STAT_W-1:0] status_word,
  output logic              irq
);
  logic [NF-1:0][LVL_W-1:0] lvl;
  logic [NF-1:0] nfull, nempty, push_blk, pop_blk;
  logic [NF-1:0] svc, err_evt, err_flag, err_clr;
  logic          irq_next;
  logic          unused_sigs;

  for (genvar i = 0; i < NF; i++) begin : g_fifo
    localparam bit TX = fifo_is_tx(i);

    fifo_level_tracker #(.DEPTH(DEPTH)) u_lvl (
      .clk          (clk),
      .rst_n        (rst_n),
      .push         (push[i]),
      .pop          (pop[i]),
      .level        (lvl[i]),
      .not_full     (nfull[i]),
      .not_empty    (nempty[i]),
      .push_blocked (push_blk[i]),
      .pop_blocked  (pop_blk[i])
    );

    service_request #(
      .IS_TX  (TX),
      .DEPTH  (DEPTH),
      .THRESH (TX ? TX_MAX : RX_MIN)
    ) u_svc (
      .enable (port_en),
      .level  (lvl[i]),
      .req    (svc[i])
    );

    // transmit side errs on pop-when-empty, receive side on push-when-full
    if (TX) begin : g_under
      assign err_evt[i] = pop_blk[i];
    end else begin : g_over
      assign err_evt[i] = push_blk[i];
    end

    assign err_clr[i] = sw_wr & sw_wdata[ERR_LSB + i];

    sticky_flag u_err (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (err_evt[i]),
      .clr_req (err_clr[i]),
      .flag    (err_flag[i])
    );
  end

  assign status_word = {
    16'h0000,
    tel_codec_on, aud_codec_on, rd_done, wr_done,
    nempty[FIFO_TEL_RX], nfull[FIFO_TEL_RX],
    nempty[FIFO_AUD_RX], nfull[FIFO_AUD_RX],
    err_flag,
    svc
  };

  assign irq_next = (|(svc & svc_mask)) | (|err_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_next;
  end

  assign unused_sigs = ^{sw_wdata[STAT_W-1:ERR_LSB+NF], sw_wdata[ERR_LSB-1:0],
                         nfull[FIFO_AUD_TX], nfull[FIFO_TEL_TX],
                         nempty[FIFO_AUD_TX], nempty[FIFO_TEL_TX]};
endmodule

// File: rtl/codec_fifo_status_chk.sv
module codec_fifo_status_chk #(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                port_en,
  input logic [3:0]          push,
  input logic [3:0]          pop,
  input logic [3:0]          svc_mask,
  input logic                sw_wr,
  input logic [31:0]         sw_wdata,
  input logic [3:0][LVL_W-1:0] lvl,
  input logic [31:0]         status_word,
  input logic                irq
);
  for (genvar i = 0; i < 4; i++) begin : g_chk
    // R1
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl[i] <= LVL_W'(DEPTH));

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[4+i] && !(sw_wr && sw_wdata[4+i]) |=> status_word[4+i]);
  end

  // R4
  aud_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop[0] && lvl[0] == '0 |=> status_word[4]);

  // R4
  tel_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push[3] && lvl[3] == LVL_W'(DEPTH) |=> status_word[7]);

  // R2
  svc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> status_word[3:0] == 4'h0);

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[31:16] == 16'h0000);

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> irq == ($past(|(status_word[3:0] & svc_mask)) || $past(|status_word[7:4])));
endmodule

bind codec_fifo_status codec_fifo_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_en     (port_en),
  .push        (push),
  .pop         (pop),
  .svc_mask    (svc_mask),
  .sw_wr       (sw_wr),
  .sw_wdata    (sw_wdata),
  .lvl         (lvl),
  .status_word (status_word),
  .irq         (irq)
);

// File: tb/codec_fifo_status_bench.sv
module codec_fifo_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        port_en;
  logic [3:0]  push, pop, svc_mask;
  logic        wr_done, rd_done, aud_codec_on, tel_codec_on;
  logic        sw_wr;
  logic [31:0] sw_wdata;
  logic [31:0] status_word;
  logic        irq;

  int total = 0;
  int bad = 0;
  int m_lvl [4];
  bit m_err [4];
  bit m_irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  codec_fifo_status u_codec_fifo_status (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .push(push), .pop(pop),
    .svc_mask(svc_mask), .wr_done(wr_done), .rd_done(rd_done),
    .aud_codec_on(aud_codec_on), .tel_codec_on(tel_codec_on),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .status_word(status_word), .irq(irq)
  );

  function automatic bit m_svc(int i);
    if (!port_en) return 1'b0;
    if (i % 2 == 0) return m_lvl[i] <= 4;
    return m_lvl[i] >= 6;
  endfunction

  function automatic logic [31:0] m_word();
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++) begin
      w[i]   = m_svc(i);
      w[4+i] = m_err[i];
    end
    w[8]  = m_lvl[1] < DEPTH;
    w[9]  = m_lvl[1] > 0;
    w[10] = m_lvl[3] < DEPTH;
    w[11] = m_lvl[3] > 0;
    w[15:12] = {tel_codec_on, aud_codec_on, rd_done, wr_done};
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [31:0] e = m_word();
    chk("R2 tx service", {30'd0, status_word[2], status_word[0]}, {30'd0, e[2], e[0]});
    chk("R3 rx service", {30'd0, status_word[3], status_word[1]}, {30'd0, e[3], e[1]});
    chk("R4 R5 error flags", {28'd0, status_word[7:4]}, {28'd0, e[7:4]});
    chk("R6 R1 rx levels", {28'd0, status_word[11:8]}, {28'd0, e[11:8]});
    chk("R7 mirrors", {28'd0, status_word[15:12]}, {28'd0, e[15:12]});
    chk("R8 reserved", {16'd0, status_word[31:16]}, 32'd0);
    chk("R9 irq", {31'd0, irq}, {31'd0, m_irq});
  endtask

  // one clock: advance the model with the inputs now applied, then check
  task automatic cycle();
    bit nirq = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (m_svc(i) && svc_mask[i]) nirq = 1'b1;
      if (m_err[i]) nirq = 1'b1;
    end
    for (int i = 0; i < 4; i++) begin
      bit evt = (i % 2 == 0) ? (pop[i] && m_lvl[i] == 0) : (push[i] && m_lvl[i] == DEPTH);
      bit pok = push[i] && m_lvl[i] < DEPTH;
      bit qok = pop[i] && m_lvl[i] > 0;
      if (evt) m_err[i] = 1'b1;
      else if (sw_wr && sw_wdata[4+i]) m_err[i] = 1'b0;
      m_lvl[i] = m_lvl[i] + int'(pok) - int'(qok);
    end
    m_irq = nirq;
    @(posedge clk);
    #1;
    check_all();
  endtask

  task automatic idle();
    push = '0; pop = '0; sw_wr = 1'b0; sw_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; port_en = 1'b0; svc_mask = '0;
    wr_done = 0; rd_done = 0; aud_codec_on = 0; tel_codec_on = 0;
    idle();
    for (int i = 0; i < 4; i++) begin m_lvl[i] = 0; m_err[i] = 0; end
    m_irq = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state, port disabled: only rx not-full bits set
    chk("R10 reset word", status_word, 32'h0000_0500);
    chk("R10 reset irq", {31'd0, irq}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4 underrun while disabled, then R5 clear via write-one
    pop = 4'b0001; cycle();
    idle(); cycle();
    chk("R4 audio underrun", {31'd0, status_word[4]}, 32'd1);
    sw_wr = 1'b1; sw_wdata = 32'hFFFF_FF0F; cycle();   // 0 in bit 4: no clear
    chk("R5 zero leaves", {31'd0, status_word[4]}, 32'd1);
    sw_wdata = 32'h0000_0010; cycle();
    chk("R5 write-one clears", {31'd0, status_word[4]}, 32'd0);
    // R5 set and clear in same cycle: set wins
    idle(); pop = 4'b0100; sw_wr = 1'b1; sw_wdata = 32'h0000_0040; cycle();
    chk("R5 set wins", {31'd0, status_word[6]}, 32'd1);
    idle(); sw_wr = 1'b1; sw_wdata = 32'h0000_00F0; cycle();

    // R3/R1 fill telecom rx past full -> overrun; R6 not-full drops
    idle(); port_en = 1'b1; svc_mask = 4'b1000;
    for (int k = 0; k < DEPTH + 2; k++) begin push = 4'b1010; cycle(); end
    idle(); cycle();
    chk("R6 telecom rx full", {31'd0, status_word[10]}, 32'd0);
    chk("R4 telecom overrun", {31'd0, status_word[7]}, 32'd1);
    // R1 push+pop while full: pop proceeds, push blocked
    push = 4'b1000; pop = 4'b1000; cycle();
    idle(); sw_wr = 1'b1; sw_wdata = 32'h0000_00F0; cycle();
    idle(); port_en = 1'b0; cycle();
    chk("R2 R3 disabled gate", {28'd0, status_word[3:0]}, 32'd0);

    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      int pp = (ph % 3 == 0) ? 75 : (ph % 3 == 1) ? 20 : 50;
      int qp = 100 - pp;
      for (int n = 0; n < 400; n++) begin
        for (int i = 0; i < 4; i++) begin
          push[i] = ($urandom % 100) < pp;
          pop[i]  = ($urandom % 100) < qp;
        end
        if ($urandom % 10 == 0) port_en = ~port_en;
        if ($urandom % 40 == 0) svc_mask = 4'($urandom);
        {tel_codec_on, aud_codec_on, rd_done, wr_done} = 4'($urandom);
        sw_wr = ($urandom % 8) == 0;
        sw_wdata = $urandom;
        cycle();
      end
    end
    idle(); cycle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule